// File: doc/BRIEF.md
# Receive Message Object Matcher

This block keeps a bank of message objects, each configured by software with an identifier, a frame format, a direction and an enable bit. A deserializer hands it one received frame at a time, all fields in parallel: the identifier, the extended-format flag, the remote-request flag, the length code and eight data bytes. The block compares the frame with every enabled receive object in the same cycle. It selects the lowest-numbered object that matches. It then writes the length and the payload into that object's own storage and raises the object's status flags, without any processor involvement.

Software sees a small register window. The upper address bits select an object and the lower four bits select a register within it. Through this window software sets up objects, reads back the stored frames and clears status flags. A one-cycle pulse with the index of the winning object tells the rest of the system that a frame was accepted.

Top module: `msg_obj_matcher`

## Requirements
- R1: After reset every object is disabled, with zero configuration, identifier, status and length, and `match_valid` is low.
- R2: Register window: `cpu_addr[7:4]` selects the object and `cpu_addr[3:0]` the register (0 config, 1 identifier, 2 status, 3 length, 4 data bytes 0..3, 5 data bytes 4..7, with byte 0 in bits 7:0). Config bit 0 is enable, bit 1 is transmit direction and bit 2 is extended format. Read data is valid on `cpu_rdata` in the cycle after `cpu_re`, flagged by `cpu_rvalid`.
- R3: An object matches only if it is enabled, has receive direction, has a format bit equal to `rx_ide`, and has equal identifier bits. A standard object compares only bits 10:0 of the identifier. An extended object compares all 29 bits.
- R4: When several objects match, the object with the lowest index is chosen.
- R5: `match_valid` pulses for one cycle, together with `match_idx`, two clock edges after the edge that samples `rx_valid`.
- R6: The stored length is the received length code, limited to 8.
- R7: For a data frame, all eight received bytes are stored. For a remote frame (`rx_rtr`=1), only the length is stored and the data registers keep their old contents.
- R8: On acceptance, status bit 0 (new data) is set. Status bit 1 (overwritten) is set if new data was already set.
- R9: A frame that matches no object leaves all status flags unchanged and produces no `match_valid` pulse.
- R10: Writing a status register clears each flag whose write-data bit is 1.
- R11: Object index 15 does not exist. Writes to it are ignored and reads from it return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_re | input | 1 | Register read strobe |
| cpu_addr | input | 8 | Object index (7:4) and register select (3:0) |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data |
| cpu_rvalid | output | 1 | Read data valid |
| rx_valid | input | 1 | Received frame present this cycle |
| rx_id | input | 29 | Received identifier (standard format uses bits 10:0) |
| rx_ide | input | 1 | Received frame is in extended format |
| rx_rtr | input | 1 | Received frame is a remote request |
| rx_dlc | input | 4 | Received length code |
| rx_data | input | 64 | Received data bytes, byte 0 in bits 7:0 |
| match_valid | output | 1 | Frame accepted into an object |
| match_idx | output | 4 | Index of the accepting object |

## Verification
The case that is hardest to reach from the ports is a frame that several objects could accept at once. In that case the lower index must win over objects that differ only in format, direction or enable. The overwritten flag must also rise only on the second hit. The random phase draws identifiers from a very small pool and reconfigures objects at random between frames, so overlapping objects and repeated hits on one object occur often. Directed frames also set identifier bits above bit 10 on standard frames, which must be ignored, and use length codes above 8.

// File: rtl/mom_pkg.sv
package mom_pkg;
  localparam int ID_W  = 29;
  localparam int SID_W = 11;
  localparam int SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_CFG  = 4'd0,
    SEL_ID   = 4'd1,
    SEL_STAT = 4'd2,
    SEL_LEN  = 4'd3,
    SEL_DLO  = 4'd4,
    SEL_DHI  = 4'd5
  } reg_sel_e;

  localparam int CFG_EN  = 0;
  localparam int CFG_TX  = 1;
  localparam int CFG_EXT = 2;
endpackage

// File: rtl/mom_cfg_bank.sv
module mom_cfg_bank #(
  parameter int NOBJ  = 15,
  parameter int IW    = 29,
  parameter int DW    = 32,
  parameter int OBJ_W = $clog2(NOBJ)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OBJ_W-1:0] wr_obj,
  input  mom_pkg::reg_sel_e wr_sel,
  input  logic [DW-1:0]    wr_data,
  output logic [NOBJ-1:0]  obj_en,
  output logic [NOBJ-1:0]  obj_tx,
  output logic [NOBJ-1:0]  obj_ext,
  output logic [IW-1:0]    obj_id [NOBJ]
);
  import mom_pkg::*;

  for (genvar g = 0; g < NOBJ; g++) begin : g_obj
    logic hit_w;
    assign hit_w = wr_en && (wr_obj == OBJ_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        obj_en[g]  <= 1'b0;
        obj_tx[g]  <= 1'b0;
        obj_ext[g] <= 1'b0;
        obj_id[g]  <= '0;
      end else if (hit_w) begin
        if (wr_sel == SEL_CFG) begin
          obj_en[g]  <= wr_data[CFG_EN];
          obj_tx[g]  <= wr_data[CFG_TX];
          obj_ext[g] <= wr_data[CFG_EXT];
        end
        if (wr_sel == SEL_ID) obj_id[g] <= wr_data[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/mom_match.sv
module mom_match #(
  parameter int NOBJ  = 15,
  parameter int IW    = 29,
  parameter int SW    = 11,
  parameter int OBJ_W = $clog2(NOBJ)
) (
  input  logic [IW-1:0]    rx_id,
  input  logic             rx_ide,
  input  logic [NOBJ-1:0]  obj_en,
  input  logic [NOBJ-1:0]  obj_tx,
  input  logic [NOBJ-1:0]  obj_ext,
  input  logic [IW-1:0]    obj_id [NOBJ],
  output logic             hit_any,
  output logic [OBJ_W-1:0] hit_idx
);
  logic [NOBJ-1:0] cand;

  for (genvar g = 0; g < NOBJ; g++) begin : g_cmp
    logic id_eq;
    always_comb begin
      if (obj_ext[g]) id_eq = (obj_id[g] == rx_id);
      else            id_eq = (obj_id[g][SW-1:0] == rx_id[SW-1:0]);
    end
    assign cand[g] = obj_en[g] && !obj_tx[g] && (obj_ext[g] == rx_ide) && id_eq;
  end

  always_comb begin
    hit_idx = '0;
    for (int i = NOBJ - 1; i >= 0; i--) begin
      if (cand[i]) hit_idx = OBJ_W'(i);
    end
  end

  assign hit_any = |cand;
endmodule

// File: rtl/mom_store.sv
module mom_store #(
  parameter int DEPTH = 15,
  parameter int W     = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  q
);
  logic [W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/msg_obj_matcher.sv
module msg_obj_matcher #(
  parameter int NOBJ   = 15,
  parameter int NBYTES = 8,
  parameter int DW     = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_we,
  input  logic                    cpu_re,
  input  logic [7:0]              cpu_addr,
  input  logic [DW-1:0]           cpu_wdata,
  output logic [DW-1:0]           cpu_rdata,
  output logic                    cpu_rvalid,
  input  logic                    rx_valid,
  input  logic [28:0]             rx_id,
  input  logic                    rx_ide,
  input  logic                    rx_rtr,
  input  logic [3:0]              rx_dlc,
  input  logic [NBYTES*8-1:0]     rx_data,
  output logic                    match_valid,
  output logic [3:0]              match_idx
);
  import mom_pkg::*;

  localparam int OBJ_W = $clog2(NOBJ);
  localparam int PW    = NBYTES * 8;
  localparam int LEN_W = 4;
  localparam int NPAD  = 1 << OBJ_W;

  // register window decode
  logic [OBJ_W-1:0] a_obj;
  reg_sel_e         a_sel;
  logic             a_ok;
  assign a_obj = cpu_addr[SEL_W +: OBJ_W];
  assign a_sel = reg_sel_e'(cpu_addr[SEL_W-1:0]);
  assign a_ok  = (a_obj < OBJ_W'(NOBJ));

  // object configuration
  logic [NOBJ-1:0] obj_en, obj_tx, obj_ext;
  logic [ID_W-1:0] obj_id [NOBJ];

  mom_cfg_bank #(.NOBJ(NOBJ), .IW(ID_W), .DW(DW), .OBJ_W(OBJ_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cpu_we && a_ok),
    .wr_obj  (a_obj),
    .wr_sel  (a_sel),
    .wr_data (cpu_wdata),
    .obj_en  (obj_en),
    .obj_tx  (obj_tx),
    .obj_ext (obj_ext),
    .obj_id  (obj_id)
  );

  // parallel acceptance test
  logic             m_any;
  logic [OBJ_W-1:0] m_idx;

  mom_match #(.NOBJ(NOBJ), .IW(ID_W), .SW(SID_W), .OBJ_W(OBJ_W)) u_match (
    .rx_id   (rx_id),
    .rx_ide  (rx_ide),
    .obj_en  (obj_en),
    .obj_tx  (obj_tx),
    .obj_ext (obj_ext),
    .obj_id  (obj_id),
    .hit_any (m_any),
    .hit_idx (m_idx)
  );

  // stage 1: registered match result and frame
  logic             s1_hit;
  logic [OBJ_W-1:0] s1_idx;
  logic             s1_rtr;
  logic [LEN_W-1:0] s1_len;
  logic [PW-1:0]    s1_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_hit <= 1'b0;
      s1_idx <= '0;
      s1_rtr <= 1'b0;
      s1_len <= '0;
    end else begin
      s1_hit <= rx_valid && m_any;
      s1_idx <= m_idx;
      s1_rtr <= rx_rtr;
      s1_len <= (rx_dlc > LEN_W'(NBYTES)) ? LEN_W'(NBYTES) : rx_dlc;
    end
  end

  always_ff @(posedge clk) begin
    if (rx_valid) s1_data <= rx_data;
  end

  // stage 2: status, length and payload update
  logic [NOBJ-1:0]  newdat, lost;
  logic [LEN_W-1:0] len_q [NOBJ];

  for (genvar g = 0; g < NOBJ; g++) begin : g_stat
    logic hw_set, sw_clr;
    assign hw_set = s1_hit && (s1_idx == OBJ_W'(g));
    assign sw_clr = cpu_we && a_ok && (a_obj == OBJ_W'(g)) && (a_sel == SEL_STAT);
    always_ff @(posedge clk) begin
      if (rst) begin
        newdat[g] <= 1'b0;
        lost[g]   <= 1'b0;
        len_q[g]  <= '0;
      end else if (hw_set) begin
        newdat[g] <= 1'b1;
        lost[g]   <= lost[g] | newdat[g];
        len_q[g]  <= s1_len;
      end else if (sw_clr) begin
        if (cpu_wdata[0]) newdat[g] <= 1'b0;
        if (cpu_wdata[1]) lost[g]   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_valid <= 1'b0;
      match_idx   <= '0;
    end else begin
      match_valid <= s1_hit;
      match_idx   <= 4'(s1_idx);
    end
  end

  logic [PW-1:0] pay_q;

  mom_store #(.DEPTH(NOBJ), .W(PW), .AW(OBJ_W)) u_store (
    .clk   (clk),
    .we    (s1_hit && !s1_rtr),
    .waddr (s1_idx),
    .wdata (s1_data),
    .re    (cpu_re && a_ok),
    .raddr (a_obj),
    .q     (pay_q)
  );

  // read-back path
  reg_sel_e      rd_sel;
  logic          rd_ok;
  logic [DW-1:0] rd_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rvalid <= 1'b0;
      rd_sel     <= SEL_CFG;
      rd_ok      <= 1'b0;
      rd_word    <= '0;
    end else begin
      cpu_rvalid <= cpu_re;
      if (cpu_re) begin
        rd_sel  <= a_sel;
        rd_ok   <= a_ok;
        rd_word <= '0;
        if (a_ok) begin
          case (a_sel)
            SEL_CFG:  rd_word <= DW'({obj_ext[a_obj], obj_tx[a_obj], obj_en[a_obj]});
            SEL_ID:   rd_word <= DW'(obj_id[a_obj]);
            SEL_STAT: rd_word <= DW'({lost[a_obj], newdat[a_obj]});
            SEL_LEN:  rd_word <= DW'(len_q[a_obj]);
            default:  rd_word <= '0;
          endcase
        end
      end
    end
  end

  always_comb begin
    if (!rd_ok)                cpu_rdata = '0;
    else if (rd_sel == SEL_DLO) cpu_rdata = pay_q[DW-1:0];
    else if (rd_sel == SEL_DHI) cpu_rdata = pay_q[2*DW-1:DW];
    else                       cpu_rdata = rd_word;
  end

  // observation signals for the bound checker
  logic [NPAD-1:0]  newdat_pad;
  logic [LEN_W-1:0] hit_len;
  assign newdat_pad = NPAD'(newdat);
  assign hit_len    = (match_idx < 4'(NOBJ)) ? len_q[match_idx[OBJ_W-1:0]] : '0;
endmodule

// File: rtl/mom_checker.sv
module mom_checker #(
  parameter int NOBJ = 15,
  parameter int NPAD = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            rx_valid,
  input logic            cpu_we,
  input logic            match_valid,
  input logic [3:0]      match_idx,
  input logic [NPAD-1:0] newdat_pad,
  input logic [3:0]      hit_len
);
  // R5
  match_delay_chk: assert property (@(posedge clk) disable iff (rst)
    match_valid |-> $past(rx_valid, 2));

  // R5
  match_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    match_valid && !$past(rx_valid) |=> !match_valid);

  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    match_valid |-> (match_idx < 4'(NOBJ)));

  // R8
  newdat_set_chk: assert property (@(posedge clk) disable iff (rst)
    match_valid |-> newdat_pad[match_idx]);

  // R6
  len_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    match_valid |-> (hit_len <= 4'd8));

  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!match_valid && !$past(cpu_we)) |-> $stable(newdat_pad));
endmodule

bind msg_obj_matcher mom_checker #(.NOBJ(NOBJ), .NPAD(NPAD)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rx_valid    (rx_valid),
  .cpu_we      (cpu_we),
  .match_valid (match_valid),
  .match_idx   (match_idx),
  .newdat_pad  (newdat_pad),
  .hit_len     (hit_len)
);

// File: tb/test_msg_obj_matcher.sv
module test_msg_obj_matcher;
  localparam int NOBJ = 15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_we = 1'b0, cpu_re = 1'b0;
  logic [7:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_rvalid;
  logic        rx_valid = 1'b0;
  logic [28:0] rx_id = '0;
  logic        rx_ide = 1'b0, rx_rtr = 1'b0;
  logic [3:0]  rx_dlc = '0;
  logic [63:0] rx_data = '0;
  logic        match_valid;
  logic [3:0]  match_idx;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  msg_obj_matcher i_msg_obj_matcher (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .rx_valid(rx_valid), .rx_id(rx_id), .rx_ide(rx_ide), .rx_rtr(rx_rtr),
    .rx_dlc(rx_dlc), .rx_data(rx_data), .match_valid(match_valid), .match_idx(match_idx)
  );

  // reference model
  bit          m_en [NOBJ], m_tx [NOBJ], m_ext [NOBJ], m_nd [NOBJ], m_ml [NOBJ];
  logic [28:0] m_id [NOBJ];
  int          m_len [NOBJ];
  logic [63:0] m_dat [NOBJ];

  function automatic int exp_hit(logic [28:0] id, bit ide);
    for (int i = 0; i < NOBJ; i++) begin
      if (m_en[i] && !m_tx[i] && (m_ext[i] == ide) &&
          (ide ? (m_id[i] == id) : (m_id[i][10:0] == id[10:0])))
        return i;
    end
    return -1;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic wr(int obj, int sel, logic [31:0] d);
    @(negedge clk);
    cpu_we = 1; cpu_addr = 8'((obj << 4) | sel); cpu_wdata = d;
    @(negedge clk);
    cpu_we = 0;
  endtask

  task automatic rd(int obj, int sel, output logic [31:0] d);
    @(negedge clk);
    cpu_re = 1; cpu_addr = 8'((obj << 4) | sel);
    @(negedge clk);
    cpu_re = 0;
    d = cpu_rdata;
  endtask

  task automatic cfg(int obj, bit en, bit tx, bit ext, logic [28:0] id);
    wr(obj, 0, {29'b0, ext, tx, en});
    wr(obj, 1, {3'b0, id});
    m_en[obj] = en; m_tx[obj] = tx; m_ext[obj] = ext; m_id[obj] = id;
  endtask

  // drives one frame, checks the pulse, updates the model; returns hit index
  task automatic send(logic [28:0] id, bit ide, bit rtr, logic [3:0] dlc,
                      logic [63:0] dat, output int h);
    h = exp_hit(id, ide);
    @(negedge clk);
    rx_valid = 1; rx_id = id; rx_ide = ide; rx_rtr = rtr; rx_dlc = dlc; rx_data = dat;
    @(negedge clk);
    rx_valid = 0;
    chk(match_valid == 0, "R5 no early pulse", match_valid, 0);
    @(negedge clk);
    if (h < 0) begin
      chk(match_valid == 0, "R9 no pulse on miss", match_valid, 0);
    end else begin
      chk(match_valid == 1 && match_idx == 4'(h), "R4 R5 winning index",
          {match_valid, match_idx}, {1'b1, 4'(h)});
      m_ml[h] = m_ml[h] | m_nd[h];
      m_nd[h] = 1;
      m_len[h] = (dlc > 8) ? 8 : int'(dlc);
      if (!rtr) m_dat[h] = dat;
    end
    @(negedge clk);
    chk(match_valid == 0, "R5 single pulse", match_valid, 0);
  endtask

  task automatic check_obj(int o);
    logic [31:0] v;
    rd(o, 2, v);
    chk(v == {30'b0, m_ml[o], m_nd[o]}, "R8 status", v, {m_ml[o], m_nd[o]});
    rd(o, 3, v);
    chk(v == 32'(m_len[o]), "R6 length", v, m_len[o]);
    rd(o, 4, v);
    chk(v == m_dat[o][31:0], "R7 data low", v, m_dat[o][31:0]);
    rd(o, 5, v);
    chk(v == m_dat[o][63:32], "R7 data high", v, m_dat[o][63:32]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int h;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NOBJ; i++) begin
      m_en[i] = 0; m_tx[i] = 0; m_ext[i] = 0; m_nd[i] = 0; m_ml[i] = 0;
      m_id[i] = '0; m_len[i] = 0; m_dat[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk(match_valid == 0, "R1 match_valid low", match_valid, 0);
    rd(3, 0, v); chk(v == 0, "R1 config zero", v, 0);
    rd(3, 1, v); chk(v == 0, "R1 identifier zero", v, 0);
    rd(3, 2, v); chk(v == 0, "R1 status zero", v, 0);
    rd(3, 3, v); chk(v == 0, "R1 length zero", v, 0);

    // R2 register window
    cfg(2, 1, 0, 0, 29'h123);
    cfg(5, 1, 0, 0, 29'h123);
    cfg(7, 1, 0, 1, 29'h123);
    cfg(9, 1, 1, 0, 29'h456);
    cfg(11, 0, 0, 0, 29'h456);
    cfg(14, 1, 0, 1, 29'h1ABCDEF0);
    rd(7, 0, v); chk(v == 32'h5, "R2 config readback", v, 5);
    rd(14, 1, v); chk(v == 32'h1ABCDEF0, "R2 identifier readback", v, 32'h1ABCDEF0);
    @(negedge clk); cpu_re = 1; cpu_addr = 8'h90;
    @(posedge clk); #1;
    chk(cpu_rvalid == 1, "R2 read valid timing", cpu_rvalid, 1);
    @(negedge clk); cpu_re = 0;

    // R11 nonexistent object
    wr(15, 0, 32'h7); wr(15, 1, 32'h123);
    rd(15, 0, v); chk(v == 0, "R11 object 15 config", v, 0);
    rd(15, 1, v); chk(v == 0, "R11 object 15 identifier", v, 0);

    // R4 lowest wins, R6 clamp, R7 data
    send(29'h123, 0, 0, 4'd12, 64'h8877665544332211, h);
    chk(h == 2, "R4 expected winner", h, 2);
    check_obj(2);
    check_obj(5);
    // R8 overwritten flag
    send(29'h123, 0, 0, 4'd3, 64'h0102030405060708, h);
    check_obj(2);
    // R3 format selects object 7
    send(29'h123, 1, 0, 4'd8, 64'hCAFEF00DDEADBEEF, h);
    chk(h == 7, "R3 extended object", h, 7);
    check_obj(7);
    // R3 R9 transmit and disabled objects do not accept
    send(29'h456, 0, 0, 4'd2, 64'h1, h);
    chk(h == -1, "R9 expected miss", h, -1);
    check_obj(9);
    check_obj(11);
    // R3 standard compares only low 11 bits
    send(29'h1F800123, 0, 0, 4'd1, 64'h55, h);
    chk(h == 2, "R3 upper bits ignored", h, 2);
    check_obj(2);
    // R7 remote frame keeps data
    send(29'h1ABCDEF0, 1, 1, 4'd3, 64'hFFFF_FFFF_FFFF_FFFF, h);
    check_obj(14);
    // R10 clear by write-one
    wr(2, 2, 32'h1); m_nd[2] = 0;
    check_obj(2);
    wr(2, 2, 32'h2); m_ml[2] = 0;
    check_obj(2);

    // random phase with a small identifier pool
    for (int it = 0; it < 400; it++) begin
      logic [28:0] pool [4];
      logic [28:0] fid;
      bit fide;
      pool[0] = 29'h010; pool[1] = 29'h011; pool[2] = 29'h1000010; pool[3] = 29'h7FF;
      if ($urandom_range(0, 3) == 0) begin
        int o;
        o = $urandom_range(0, NOBJ - 1);
        cfg(o, $urandom_range(0, 3) != 0, $urandom_range(0, 4) == 0,
            $urandom_range(0, 1), pool[$urandom_range(0, 3)]);
      end
      if ($urandom_range(0, 5) == 0) begin
        int o;
        o = $urandom_range(0, NOBJ - 1);
        wr(o, 2, 32'($urandom_range(0, 3)));
        if (cpu_wdata[0]) m_nd[o] = 0;
        if (cpu_wdata[1]) m_ml[o] = 0;
      end
      fid  = pool[$urandom_range(0, 3)];
      fide = $urandom_range(0, 1);
      send(fid, fide, $urandom_range(0, 3) == 0, 4'($urandom_range(0, 15)),
           {$urandom, $urandom}, h);
      if (h >= 0) check_obj(h);
    end

    finish_run();
  end
endmodule